// File: doc/BRIEF.md
# Voltage-ID Step Supervisor

This block is the digital sequencer that sits beside the analog reference ramp of a step-down regulator controller. It watches a 2-bit voltage-ID code and decides which setpoint code the reference should track. It also decides, cycle by cycle, which supervisory behaviour is in force: a fast or slow ramp current, forced continuous conduction, a raised overcurrent limit, whether power-good, undervoltage and overvoltage protection are live, and whether the power stage switches at all. One clock cycle is one internal timing tick.

During startup the setpoint is pinned to the highest code, whatever the pins say. Once soft-start ends, a filtered change on the pins starts a transition. The transition runs at high ramp current, in forced continuous mode and with a raised current limit, and with every protection blanked. When the analog side reports that the ramp has arrived, a settle window of fixed length keeps the blanking in place before normal operation returns. If the ramp clamp stays engaged for long enough during a blanked window, protection is re-armed so that a shorted output can still shut the controller down. Code 00 parks the converter: switching stops while power-good stays high.

Top module: `vid_step_seq`

## Requirements
- R1: From reset until `ss_done` is first sampled high, `vid_eff` is 2'b11 regardless of `vid_pins`.
- R2: A new pin code is acted on only once it has been sampled at FILT_DEPTH (2) consecutive clock edges. `vid_eff` takes the new code at the edge after the second such sample. A code present for a single sample is ignored.
- R3: `slew_fast` is 1 exactly while a transition is ramping: from the edge that loads a new `vid_eff` until the edge that samples `ramp_done` high.
- R4: `fccm_en` and `ocl_boost` are 1 from the start of a transition through the end of its settle window, and 0 in normal operation and in the parked state.
- R5: The settle window starts at the edge that samples `ramp_done` high during a ramp and lasts SETTLE_TICKS (16) cycles. Throughout the ramp and the settle window, `pg_gate`, `uvp_en` and `ovp_en` are 0, except as R6 allows.
- R6: If `clamp_active` is sampled high at CLAMP_TICKS (32) consecutive edges while in a ramp or settle window, `uvp_en` and `ovp_en` are 1 from the edge of the 32nd sample until the clamp drops or the window ends. After 31 samples they are still 0.
- R7: Code 00 parks the converter: `sw_stop`=1, `pg_gate`=1, and `uvp_en`, `ovp_en`, `fccm_en` and `slew_fast` are 0.
- R8: Leaving code 00 for any nonzero code starts a normal transition: `sw_stop`=0 and the behaviour of R3 to R5 applies.
- R9: A filtered code change during a ramp or a settle window restarts the transition at once. The settle window of the new transition has the full SETTLE_TICKS length.
- R10: While `rst_n` is sampled low, the next cycle shows `vid_eff`=2'b11, `sw_stop`=1 and `pg_gate`, `uvp_en`, `ovp_en`, `fccm_en`, `ocl_boost`, `slew_fast` all 0.
- R11: In normal operation after a settle window, or after soft-start with no pending change, `pg_gate`, `uvp_en` and `ovp_en` are 1, and `sw_stop`, `fccm_en`, `ocl_boost` and `slew_fast` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal tick clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vid_pins | input | VID_W | Raw voltage-ID code from the pins |
| ss_done | input | 1 | Soft-start has finished |
| ramp_done | input | 1 | Reference ramp has reached its target |
| clamp_active | input | 1 | Ramp clamp engaged by the analog side |
| vid_eff | output | VID_W | Setpoint code passed to the reference |
| slew_fast | output | 1 | 1 selects the high ramp current, 0 the soft-start current |
| fccm_en | output | 1 | Forced continuous conduction |
| ocl_boost | output | 1 | Overcurrent limit raised to 125 percent |
| uvp_en | output | 1 | Undervoltage protection live |
| ovp_en | output | 1 | Overvoltage protection live |
| pg_gate | output | 1 | Power-good allowed to report high |
| sw_stop | output | 1 | Stop switching of both drivers |

## Verification
Every result is registered. A pin change shows on `vid_eff` and on the transition outputs at the third edge after the pins settle. `ramp_done` and `clamp_active` act at the edge that samples them, and the settle expiry shows 16 edges after `ramp_done` was sampled. The bench drives inputs on the falling edge and keeps a cycle model of these latencies that advances on each rising edge. It compares every output on the following falling edge, so the model and the design are always compared at the same edge count. Directed segments place the filter glitch, the 31 and 32 clamp runs, a restart inside the settle window and the entry to and exit from code 00 at known cycles. A long random segment then mixes them.

// File: rtl/vid_step_pkg.sv
package vid_step_pkg;

   typedef enum logic [2:0] {
      PH_SOFT = 3'd0,
      PH_RUN  = 3'd1,
      PH_RAMP = 3'd2,
      PH_HOLD = 3'd3,
      PH_PARK = 3'd4
   } seq_phase_e;

endpackage

// File: rtl/vid_pin_filter.sv
module vid_pin_filter #(
   parameter int W     = 2,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pins,
   output logic [W-1:0] code,
   output logic         steady
);

   logic [W-1:0] hist [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) hist[i] <= '1;
      end else begin
         hist[0] <= pins;
         for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
      end
   end

   assign code = hist[0];

   generate
      if (DEPTH == 1) begin : g_single
         assign steady = 1'b1;
      end else begin : g_multi
         always_comb begin
            steady = 1'b1;
            for (int i = 1; i < DEPTH; i++)
               if (hist[i] != hist[0]) steady = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/vid_interval_timer.sv
module vid_interval_timer #(
   parameter int LOAD  = 16,
   parameter int CNT_W = $clog2(LOAD + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= CNT_W'(LOAD);
      else if (run && cnt != '0)
         cnt <= cnt - CNT_W'(1);
   end

   assign expired = run && (cnt == CNT_W'(1));

endmodule

// File: rtl/vid_run_detector.sv
module vid_run_detector #(
   parameter int LIMIT = 32,
   parameter int CNT_W = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic reached
);

   logic [CNT_W-1:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n)
         run_len <= '0;
      else if (!active)
         run_len <= '0;
      else if (run_len != CNT_W'(LIMIT))
         run_len <= run_len + CNT_W'(1);
   end

   assign reached = (run_len == CNT_W'(LIMIT));

endmodule

// File: rtl/vid_step_seq.sv
module vid_step_seq
   import vid_step_pkg::*;
#(
   parameter int VID_W        = 2,
   parameter int FILT_DEPTH   = 2,
   parameter int SETTLE_TICKS = 16,
   parameter int CLAMP_TICKS  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VID_W-1:0] vid_pins,
   input  logic             ss_done,
   input  logic             ramp_done,
   input  logic             clamp_active,
   output logic [VID_W-1:0] vid_eff,
   output logic             slew_fast,
   output logic             fccm_en,
   output logic             ocl_boost,
   output logic             uvp_en,
   output logic             ovp_en,
   output logic             pg_gate,
   output logic             sw_stop
);

   localparam int               SET_W    = $clog2(SETTLE_TICKS + 1);
   localparam int               CLP_W    = $clog2(CLAMP_TICKS + 1);
   localparam logic [VID_W-1:0] CODE_TOP = '1;
   localparam logic [VID_W-1:0] CODE_OFF = '0;

   generate
      if (VID_W < 2)        begin : g_bad_w   $error("VID_W must be at least 2");       end
      if (FILT_DEPTH < 1)   begin : g_bad_f   $error("FILT_DEPTH must be at least 1");  end
      if (SETTLE_TICKS < 1) begin : g_bad_s   $error("SETTLE_TICKS must be positive");  end
      if (CLAMP_TICKS < 1)  begin : g_bad_c   $error("CLAMP_TICKS must be positive");   end
   endgenerate

   seq_phase_e       phase_q, phase_d;
   logic [VID_W-1:0] vid_q, vid_d;
   logic             started_q;
   logic [VID_W-1:0] filt_code;
   logic             filt_steady;
   logic             code_change;
   logic             blanked;
   logic             settle_load;
   logic             settle_over;
   logic             clamp_trip;

   vid_pin_filter #(.W(VID_W), .DEPTH(FILT_DEPTH)) u_filter (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins   (vid_pins),
      .code   (filt_code),
      .steady (filt_steady)
   );

   vid_interval_timer #(.LOAD(SETTLE_TICKS), .CNT_W(SET_W)) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (settle_load),
      .run     (phase_q == PH_HOLD),
      .expired (settle_over)
   );

   vid_run_detector #(.LIMIT(CLAMP_TICKS), .CNT_W(CLP_W)) u_clamp (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (clamp_active && blanked),
      .reached (clamp_trip)
   );

   assign code_change = filt_steady && (filt_code != vid_q);
   assign blanked     = (phase_q == PH_RAMP) || (phase_q == PH_HOLD);

   always_comb begin
      phase_d     = phase_q;
      vid_d       = vid_q;
      settle_load = 1'b0;
      unique case (phase_q)
         PH_SOFT: begin
            if (ss_done) begin
               if (code_change) begin
                  vid_d   = filt_code;
                  phase_d = (filt_code == CODE_OFF) ? PH_PARK : PH_RAMP;
               end else begin
                  phase_d = PH_RUN;
               end
            end
         end
         PH_RUN, PH_PARK: begin
            if (code_change) begin
               vid_d   = filt_code;
               phase_d = (filt_code == CODE_OFF) ? PH_PARK : PH_RAMP;
            end
         end
         PH_RAMP: begin
            if (code_change) begin
               vid_d   = filt_code;
               phase_d = (filt_code == CODE_OFF) ? PH_PARK : PH_RAMP;
            end else if (ramp_done) begin
               phase_d     = PH_HOLD;
               settle_load = 1'b1;
            end
         end
         PH_HOLD: begin
            if (code_change) begin
               vid_d   = filt_code;
               phase_d = (filt_code == CODE_OFF) ? PH_PARK : PH_RAMP;
            end else if (settle_over) begin
               phase_d = PH_RUN;
            end
         end
         default: phase_d = PH_SOFT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= PH_SOFT;
         vid_q     <= CODE_TOP;
         started_q <= 1'b0;
      end else begin
         phase_q   <= phase_d;
         vid_q     <= vid_d;
         started_q <= 1'b1;
      end
   end

   assign vid_eff   = vid_q;
   assign slew_fast = (phase_q == PH_RAMP);
   assign fccm_en   = blanked;
   assign ocl_boost = blanked;
   assign uvp_en    = (phase_q == PH_RUN) || (blanked && clamp_trip);
   assign ovp_en    = (phase_q == PH_RUN) || (blanked && clamp_trip);
   assign pg_gate   = (phase_q == PH_RUN) || (phase_q == PH_PARK);
   assign sw_stop   = !started_q || (phase_q == PH_PARK);

endmodule

// File: rtl/vid_step_checks.sv
module vid_step_checks #(
   parameter int VID_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ss_done,
   input logic [VID_W-1:0] vid_eff,
   input logic             slew_fast,
   input logic             fccm_en,
   input logic             ocl_boost,
   input logic             uvp_en,
   input logic             ovp_en,
   input logic             pg_gate,
   input logic             sw_stop
);

   logic ss_seen;

   always_ff @(posedge clk) begin
      if (!rst_n)       ss_seen <= 1'b0;
      else if (ss_done) ss_seen <= 1'b1;
   end

   a_r1_top_code_in_softstart: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_seen |-> (vid_eff == '1));

   a_r3_fast_slew_in_transition: assert property (@(posedge clk) disable iff (!rst_n)
      slew_fast |-> (fccm_en && ocl_boost && !pg_gate));

   a_r4_boost_tracks_fccm: assert property (@(posedge clk) disable iff (!rst_n)
      fccm_en == ocl_boost);

   a_r5_no_pg_while_blanked: assert property (@(posedge clk) disable iff (!rst_n)
      fccm_en |-> !pg_gate);

   a_r6_protections_paired: assert property (@(posedge clk) disable iff (!rst_n)
      uvp_en == ovp_en);

   a_r7_park_keeps_pg: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_stop && pg_gate) |-> (!uvp_en && !fccm_en && !slew_fast && vid_eff == '0));

   a_r10_reset_state: assert property (@(posedge clk)
      !rst_n |=> (sw_stop && vid_eff == '1 && !pg_gate && !uvp_en && !fccm_en));

endmodule

bind vid_step_seq vid_step_checks #(.VID_W(VID_W)) u_checks (
   .clk       (clk),
   .rst_n     (rst_n),
   .ss_done   (ss_done),
   .vid_eff   (vid_eff),
   .slew_fast (slew_fast),
   .fccm_en   (fccm_en),
   .ocl_boost (ocl_boost),
   .uvp_en    (uvp_en),
   .ovp_en    (ovp_en),
   .pg_gate   (pg_gate),
   .sw_stop   (sw_stop)
);

// File: tb/vid_step_seq_test.sv
`timescale 1ns/1ps
module vid_step_seq_test;

   localparam int SETTLE = 16;
   localparam int CLAMP  = 32;
   localparam int M_SOFT = 0, M_RUN = 1, M_RAMP = 2, M_HOLD = 3, M_PARK = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] vid_pins = 2'b11;
   logic       ss_done = 1'b0;
   logic       ramp_done = 1'b0;
   logic       clamp_active = 1'b0;
   logic [1:0] vid_eff;
   logic       slew_fast, fccm_en, ocl_boost, uvp_en, ovp_en, pg_gate, sw_stop;

   int checks = 0;
   int errors = 0;
   bit chk_on = 1'b0;
   bit finished = 1'b0;

   // cycle model state
   logic [1:0] m_h0, m_h1, m_vid;
   int         m_ph, m_tmr, m_crun;
   bit         m_started;

   always #2.5 clk = ~clk;

   vid_step_seq uut (
      .clk(clk), .rst_n(rst_n), .vid_pins(vid_pins), .ss_done(ss_done),
      .ramp_done(ramp_done), .clamp_active(clamp_active), .vid_eff(vid_eff),
      .slew_fast(slew_fast), .fccm_en(fccm_en), .ocl_boost(ocl_boost),
      .uvp_en(uvp_en), .ovp_en(ovp_en), .pg_gate(pg_gate), .sw_stop(sw_stop)
   );

   function automatic bit blank_ph(int ph);
      return (ph == M_RAMP) || (ph == M_HOLD);
   endfunction

   function automatic bit exp_prot();
      return (m_ph == M_RUN) || (blank_ph(m_ph) && m_crun == CLAMP);
   endfunction

   always @(posedge clk) begin
      bit         steady, chg, act;
      int         nph, ntmr, ncrun;
      logic [1:0] nvid;
      if (!rst_n) begin
         m_h0 = 2'b11; m_h1 = 2'b11; m_vid = 2'b11;
         m_ph = M_SOFT; m_tmr = 0; m_crun = 0; m_started = 0;
      end else begin
         steady = (m_h0 == m_h1);
         chg    = steady && (m_h0 != m_vid);
         act    = clamp_active && blank_ph(m_ph);
         ncrun  = act ? ((m_crun == CLAMP) ? CLAMP : m_crun + 1) : 0;
         nph = m_ph; nvid = m_vid;
         ntmr = (m_ph == M_HOLD && m_tmr != 0) ? m_tmr - 1 : m_tmr;
         if ((m_ph != M_SOFT || ss_done) && chg) begin
            nvid = m_h0;
            nph  = (m_h0 == 2'b00) ? M_PARK : M_RAMP;
         end else if (m_ph == M_SOFT && ss_done) begin
            nph = M_RUN;
         end else if (m_ph == M_RAMP && ramp_done) begin
            nph = M_HOLD; ntmr = SETTLE;
         end else if (m_ph == M_HOLD && m_tmr == 1) begin
            nph = M_RUN;
         end
         m_h1 = m_h0; m_h0 = vid_pins;
         m_ph = nph; m_vid = nvid; m_tmr = ntmr; m_crun = ncrun;
         m_started = 1;
      end
   end

   task automatic chk(string tag, string nm, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         chk("R1 R2 R8 R9", "vid_eff", vid_eff, m_vid);
         chk("R3", "slew_fast", slew_fast, m_ph == M_RAMP);
         chk("R4", "fccm_en", fccm_en, blank_ph(m_ph));
         chk("R4", "ocl_boost", ocl_boost, blank_ph(m_ph));
         chk("R5 R6 R11", "uvp_en", uvp_en, exp_prot());
         chk("R5 R6 R11", "ovp_en", ovp_en, exp_prot());
         chk("R5 R7 R11", "pg_gate", pg_gate, (m_ph == M_RUN) || (m_ph == M_PARK));
         chk("R7 R10", "sw_stop", sw_stop, !m_started || m_ph == M_PARK);
      end
   end

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(100000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd5150));
      cyc(3);
      chk_on = 1'b1;
      // R10: reset state visible while reset held
      chk("R10", "sw_stop in reset", sw_stop, 1);
      chk("R10", "vid_eff in reset", vid_eff, 3);
      rst_n = 1'b1;
      // R1: pins move during soft-start, code stays 11
      vid_pins = 2'b01; cyc(6);
      chk("R1", "vid_eff during soft-start", vid_eff, 3);
      ss_done = 1'b1; cyc(4);            // R8-like ramp to 01 begins
      cyc(5); ramp_done = 1'b1; cyc(1); ramp_done = 1'b0;
      cyc(SETTLE - 1);
      chk("R5", "still blanked at 15", pg_gate, 0);
      cyc(1);
      chk("R11", "normal after 16", pg_gate, 1);
      // R2: single-sample glitch ignored
      vid_pins = 2'b10; cyc(1); vid_pins = 2'b01; cyc(4);
      chk("R2", "glitch ignored", vid_eff, 1);
      // R6: 31 clamp samples then 32
      vid_pins = 2'b10; cyc(4);
      clamp_active = 1'b1; cyc(31);
      chk("R6", "no rearm after 31", uvp_en, 0);
      cyc(1);
      chk("R6", "rearm after 32", uvp_en, 1);
      clamp_active = 1'b0; cyc(1);
      // R9: restart inside settle window
      ramp_done = 1'b1; cyc(1); ramp_done = 1'b0; cyc(8);
      vid_pins = 2'b11; cyc(6);
      chk("R9", "restarted ramp", slew_fast, 1);
      ramp_done = 1'b1; cyc(1); ramp_done = 1'b0; cyc(SETTLE + 2);
      // R7 and R8: park and leave
      vid_pins = 2'b00; cyc(5);
      chk("R7", "parked stop", sw_stop, 1);
      chk("R7", "parked pg", pg_gate, 1);
      vid_pins = 2'b10; cyc(4);
      chk("R8", "unparked ramp", fccm_en, 1);
      // random mix, with one mid-run reset
      for (int i = 0; i < 6000; i++) begin
         if (i == 3000) begin rst_n = 1'b0; ss_done = 1'b0; end
         if (i == 3002) rst_n = 1'b1;
         if (i == 3040) ss_done = 1'b1;
         if ($urandom % 25 == 0) vid_pins = 2'($urandom);
         ramp_done = ($urandom % 9 == 0);
         if ($urandom % 45 == 0) clamp_active = ~clamp_active;
         cyc(1);
      end
      finish_run();
   end

endmodule